// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the bus work a 16-bit processor does once it has decided to take an interrupt. A one-cycle accept pulse captures the interrupt source class, its priority level, the vector address, the stack pointer, the bus-width mode, the flag word and the return PC. The block then drives a fixed order of single-cycle bus transfers: it reads the interrupt information word, leaves an optional prefetch slot, pushes two words onto the stack, and fetches the two halves of the new PC from the vector.

The whole sequence is padded to a total length. That length depends on the parity of the vector and of the stack pointer, on the bus width, and on the interrupt class. In the last cycle the block raises a done pulse and presents the assembled 20-bit PC. At the same clock edge it updates the processor interrupt priority level (IPL) by a per-source rule. An accept that arrives while a sequence is running is dropped.

Top module: `irq_entry_seq`

## Requirements
- R1: Cycle k is the k-th cycle after the clock edge that samples the accept. The bus transfers run in this order: cycle 1 reads address 0; cycle 2 reads the saved PC address only when `queue_ready_i` is 1, and otherwise drives no request; cycle 3 writes `{pc[19:16], flags[11:0]}` to SP-2; cycle 4 writes `pc[15:0]` to SP-4; cycle 5 reads the vector address; cycle 6 reads vector+2. Stack addresses are the 16-bit SP result, zero-extended to 20 bits.
- R2: With `bus8_i`=0, the total length T is 18 plus the number of odd values among vector bit 0 and SP bit 0. `done_o` is high in cycle T only.
- R3: With `bus8_i`=1, T is 20 whatever the parities are.
- R4: Class encodings are 0 leveled, 1 watchdog, 2 non-maskable, 3 reset, 4 debugger, 5 address match, 6 single step, 7 other unleveled. The debugger class adds 2 cycles to T. Address match and single step add 1 cycle.
- R5: After a class-0 sequence, `ipl_o` equals the captured level from the cycle after done onward.
- R6: After done, the watchdog and non-maskable classes set `ipl_o` to 7 and the reset class sets it to 0. Classes 4 to 7 leave `ipl_o` unchanged. `ipl_o` is 0 after reset.
- R7: In the done cycle, `new_pc_o` equals `{word_read_in_cycle6[3:0], word_read_in_cycle5}`.
- R8: An accept sampled while `busy_o` is 1, including in the done cycle, is ignored. It changes neither the transfers, nor T, nor any captured operand.
- R9: `busy_o` is 1 from cycle 1 through cycle T and 0 after that. Cycles 7 to T issue no bus request.
- R10: `info_o` holds the word read in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted, one-cycle pulse |
| class_i | input | 3 | Source class (R4 encoding) |
| level_i | input | 3 | Priority level of a leveled source |
| vec_i | input | 20 | Vector address |
| sp_i | input | 16 | Stack pointer |
| bus8_i | input | 1 | 1 selects the 8-bit bus timing |
| flags_i | input | 12 | Flag word to push |
| pc_i | input | 20 | Return PC to push |
| queue_ready_i | input | 1 | Prefetch queue can take a word |
| bus_rdata_i | input | 16 | Read data, valid in the request cycle |
| bus_req_o | output | 1 | Bus transfer in this cycle |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | 20 | Transfer address |
| bus_wdata_o | output | 16 | Write data |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Last cycle of the sequence |
| new_pc_o | output | 20 | PC assembled from the vector |
| ipl_o | output | 3 | Processor interrupt priority level |
| info_o | output | 16 | Interrupt information word |

## Verification
A new accept and the completion of a running sequence can meet in the same cycle. Completion means the done pulse, the IPL update and the drop of busy. The bench provokes this in two ways. It raises accept, together with a different class, vector and bus mode, in the middle of a sequence. It also raises accept in exactly the done cycle. It then judges the result at the ports: every transfer, the done cycle and the IPL must follow the first request's operands, and busy must fall one cycle after done with no second sequence starting.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    SRC_LEVELED    = 3'd0,
    SRC_WDOG       = 3'd1,
    SRC_NMI        = 3'd2,
    SRC_RESET      = 3'd3,
    SRC_DEBUG      = 3'd4,
    SRC_ADDR_MATCH = 3'd5,
    SRC_STEP       = 3'd6,
    SRC_PLAIN      = 3'd7
  } src_e;

  localparam int SLOT_INFO    = 1;
  localparam int SLOT_QUEUE   = 2;
  localparam int SLOT_PUSH_HI = 3;
  localparam int SLOT_PUSH_LO = 4;
  localparam int SLOT_VEC_LO  = 5;
  localparam int SLOT_VEC_HI  = 6;

endpackage

// File: rtl/irq_cycle_budget.sv
module irq_cycle_budget
  import irq_entry_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int BASE16 = 18,
  parameter int BASE8  = 20
) (
  input  logic             bus8_i,
  input  logic             vec_odd_i,
  input  logic             sp_odd_i,
  input  src_e             src_i,
  output logic [CNT_W-1:0] total_o
);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] adder;

  always_comb begin
    if (bus8_i) base = CNT_W'(BASE8);
    else        base = CNT_W'(BASE16) + CNT_W'(vec_odd_i) + CNT_W'(sp_odd_i);
  end

  always_comb begin
    unique case (src_i)
      SRC_DEBUG:                adder = CNT_W'(2);
      SRC_ADDR_MATCH, SRC_STEP: adder = CNT_W'(1);
      default:                  adder = '0;
    endcase
  end

  assign total_o = base + adder;

  always_comb begin
    a_r3_bus8_floor: assert (!bus8_i || total_o >= CNT_W'(BASE8));
  end

endmodule

// File: rtl/irq_ipl_select.sv
module irq_ipl_select
  import irq_entry_pkg::*;
#(
  parameter int IPL_W = 3
) (
  input  src_e             src_i,
  input  logic [IPL_W-1:0] level_i,
  input  logic [IPL_W-1:0] cur_i,
  output logic [IPL_W-1:0] next_o
);

  always_comb begin
    unique case (src_i)
      SRC_LEVELED:         next_o = level_i;
      SRC_WDOG, SRC_NMI:   next_o = '1;
      SRC_RESET:           next_o = '0;
      default:             next_o = cur_i;
    endcase
  end

endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
  import irq_entry_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int SP_W  = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [AW-1:0]    vec_i,
  input  logic [SP_W-1:0]  sp_i,
  input  logic [AW-1:0]    fetch_addr_i,
  input  logic [DW-1:0]    push_hi_i,
  input  logic [DW-1:0]    push_lo_i,
  input  logic             queue_ready_i,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    new_pc_o,
  output logic [DW-1:0]    info_o
);

  localparam int HI_W = AW - DW;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DW-1:0]    info_q;
  logic [DW-1:0]    vlo_q;
  logic [HI_W-1:0]  vhi_q;
  logic [SP_W-1:0]  sp_m2, sp_m4;

  assign sp_m2  = sp_i - SP_W'(2);
  assign sp_m4  = sp_i - SP_W'(4);
  assign done_o = busy_q && (cnt_q == total_i);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(1);
      busy_q <= 1'b1;
    end else if (done_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    if (busy_q) begin
      case (cnt_q)
        CNT_W'(SLOT_INFO): begin
          bus_req_o = 1'b1;
        end
        CNT_W'(SLOT_QUEUE): begin
          // prefetch slot, only when the queue has room
          bus_req_o  = queue_ready_i;
          bus_addr_o = fetch_addr_i;
        end
        CNT_W'(SLOT_PUSH_HI): begin
          bus_req_o   = 1'b1;
          bus_we_o    = 1'b1;
          bus_addr_o  = AW'(sp_m2);
          bus_wdata_o = push_hi_i;
        end
        CNT_W'(SLOT_PUSH_LO): begin
          bus_req_o   = 1'b1;
          bus_we_o    = 1'b1;
          bus_addr_o  = AW'(sp_m4);
          bus_wdata_o = push_lo_i;
        end
        CNT_W'(SLOT_VEC_LO): begin
          bus_req_o  = 1'b1;
          bus_addr_o = vec_i;
        end
        CNT_W'(SLOT_VEC_HI): begin
          bus_req_o  = 1'b1;
          bus_addr_o = vec_i + AW'(2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      info_q <= '0;
      vlo_q  <= '0;
      vhi_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(SLOT_INFO))   info_q <= bus_rdata_i;
      if (cnt_q == CNT_W'(SLOT_VEC_LO)) vlo_q  <= bus_rdata_i;
      if (cnt_q == CNT_W'(SLOT_VEC_HI)) vhi_q  <= bus_rdata_i[HI_W-1:0];
    end
  end

  assign new_pc_o = {vhi_q, vlo_q};
  assign info_o   = info_q;

  a_r1_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> bus_req_o && !bus_we_o && bus_addr_o == '0);

  a_r1_push_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o && !$past(bus_we_o) |=> bus_we_o);

  a_r9_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q > CNT_W'(SLOT_VEC_HI) |-> !bus_req_o);

  a_r9_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> busy_o);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int SP_W   = 16,
  parameter int IPL_W  = 3,
  parameter int CNT_W  = 5,
  parameter int BASE16 = 18,
  parameter int BASE8  = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    accept_i,
  input  logic [2:0]              class_i,
  input  logic [IPL_W-1:0]        level_i,
  input  logic [AW-1:0]           vec_i,
  input  logic [SP_W-1:0]         sp_i,
  input  logic                    bus8_i,
  input  logic [DW-(AW-DW)-1:0]   flags_i,
  input  logic [AW-1:0]           pc_i,
  input  logic                    queue_ready_i,
  input  logic [DW-1:0]           bus_rdata_i,
  output logic                    bus_req_o,
  output logic                    bus_we_o,
  output logic [AW-1:0]           bus_addr_o,
  output logic [DW-1:0]           bus_wdata_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [AW-1:0]           new_pc_o,
  output logic [IPL_W-1:0]        ipl_o,
  output logic [DW-1:0]           info_o
);

  localparam int HI_W  = AW - DW;
  localparam int FLG_W = DW - HI_W;

  src_e             src_q;
  logic [IPL_W-1:0] level_q, ipl_q, ipl_next;
  logic [AW-1:0]    vec_q, pc_q;
  logic [SP_W-1:0]  sp_q;
  logic [FLG_W-1:0] flags_q;
  logic [CNT_W-1:0] total_d, total_q;
  logic             start;

  assign start = accept_i && !busy_o;

  irq_cycle_budget #(
    .CNT_W (CNT_W),
    .BASE16(BASE16),
    .BASE8 (BASE8)
  ) u_budget (
    .bus8_i   (bus8_i),
    .vec_odd_i(vec_i[0]),
    .sp_odd_i (sp_i[0]),
    .src_i    (src_e'(class_i)),
    .total_o  (total_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= SRC_PLAIN;
      level_q <= '0;
      vec_q   <= '0;
      sp_q    <= '0;
      pc_q    <= '0;
      flags_q <= '0;
      total_q <= '0;
    end else if (start) begin
      src_q   <= src_e'(class_i);
      level_q <= level_i;
      vec_q   <= vec_i;
      sp_q    <= sp_i;
      pc_q    <= pc_i;
      flags_q <= flags_i;
      total_q <= total_d;
    end
  end

  irq_bus_seq #(
    .AW   (AW),
    .DW   (DW),
    .SP_W (SP_W),
    .CNT_W(CNT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .total_i      (total_q),
    .vec_i        (vec_q),
    .sp_i         (sp_q),
    .fetch_addr_i (pc_q),
    .push_hi_i    ({pc_q[AW-1:DW], flags_q}),
    .push_lo_i    (pc_q[DW-1:0]),
    .queue_ready_i(queue_ready_i),
    .bus_rdata_i  (bus_rdata_i),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .new_pc_o     (new_pc_o),
    .info_o       (info_o)
  );

  irq_ipl_select #(.IPL_W(IPL_W)) u_ipl (
    .src_i  (src_q),
    .level_i(level_q),
    .cur_i  (ipl_q),
    .next_o (ipl_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ipl_q <= '0;
    else if (done_o) ipl_q <= ipl_next;
  end

  assign ipl_o = ipl_q;

  a_r8_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && accept_i |=> $stable(total_q) && $stable(vec_q) && $stable(sp_q));

  a_r6_nmi_ipl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (src_q == SRC_WDOG || src_q == SRC_NMI) |=> ipl_o == '1);

  a_r6_reset_ipl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && src_q == SRC_RESET |=> ipl_o == '0);

  a_r5_level_ipl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && src_q == SRC_LEVELED |=> ipl_o == $past(level_q));

  a_r6_ipl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(ipl_o));

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_i = 1'b0;
  logic [2:0]  class_i = '0;
  logic [2:0]  level_i = '0;
  logic [19:0] vec_i = '0;
  logic [15:0] sp_i = '0;
  logic        bus8_i = 1'b0;
  logic [11:0] flags_i = '0;
  logic [19:0] pc_i = '0;
  logic        queue_ready_i = 1'b0;
  logic [15:0] bus_rdata_i = '0;
  logic        bus_req_o, bus_we_o, busy_o, done_o;
  logic [19:0] bus_addr_o, new_pc_o;
  logic [15:0] bus_wdata_o, info_o;
  logic [2:0]  ipl_o;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_ipl = 3'd0;

  always #4 clk = ~clk;

  irq_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .accept_i(accept_i), .class_i(class_i),
    .level_i(level_i), .vec_i(vec_i), .sp_i(sp_i), .bus8_i(bus8_i),
    .flags_i(flags_i), .pc_i(pc_i), .queue_ready_i(queue_ready_i),
    .bus_rdata_i(bus_rdata_i), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .busy_o(busy_o),
    .done_o(done_o), .new_pc_o(new_pc_o), .ipl_o(ipl_o), .info_o(info_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_total(input logic [2:0] src, input logic b8,
                                   input logic vo, input logic so);
    int t;
    t = b8 ? 20 : 18 + int'(vo) + int'(so);
    if (src == 3'd4) t += 2;
    else if (src == 3'd5 || src == 3'd6) t += 1;
    return t;
  endfunction

  function automatic logic [2:0] next_ipl(input logic [2:0] src, input logic [2:0] lvl,
                                          input logic [2:0] cur);
    case (src)
      3'd0:       return lvl;
      3'd1, 3'd2: return 3'd7;
      3'd3:       return 3'd0;
      default:    return cur;
    endcase
  endfunction

  // ign: 0 none, 1 stray accept mid-run, 2 stray accept in done cycle
  task automatic run_one(input logic [2:0] src, input logic [2:0] lvl, input logic [19:0] vec,
                         input logic [15:0] sp, input logic b8, input logic [11:0] flg,
                         input logic [19:0] pc, input logic qr, input int ign);
    int t;
    string tg;
    logic [15:0] w1, w5, w6, spm2, spm4;
    t  = exp_total(src, b8, vec[0], sp[0]);
    tg = b8 ? "R3" : ((src >= 3'd4 && src <= 3'd6) ? "R4" : "R2");
    w1 = 16'($urandom); w5 = 16'($urandom); w6 = 16'($urandom);
    spm2 = sp - 16'd2; spm4 = sp - 16'd4;
    @(negedge clk);
    class_i = src; level_i = lvl; vec_i = vec; sp_i = sp; bus8_i = b8;
    flags_i = flg; pc_i = pc; queue_ready_i = qr; accept_i = 1'b1;
    for (int k = 1; k <= t; k++) begin
      @(negedge clk);
      if (k == 1) accept_i = 1'b0;
      if (ign == 1 && k == 4) begin
        accept_i = 1'b1; class_i = 3'd4; vec_i = ~vec; sp_i = ~sp; bus8_i = ~b8;
      end
      if (ign == 1 && k == 5) accept_i = 1'b0;
      if (ign == 2 && k == t) accept_i = 1'b1;
      chk("R9 busy during run", 32'(busy_o), 32'd1);
      chk({tg, " done timing"}, 32'(done_o), 32'(k == t));
      bus_rdata_i = 16'($urandom);
      case (k)
        1: begin
          bus_rdata_i = w1;
          chk("R1 info read", {bus_req_o, bus_we_o, bus_addr_o}, {2'b10, 20'h0});
        end
        2: begin
          chk("R1 queue slot req", 32'(bus_req_o), 32'(qr));
          if (qr) chk("R1 queue slot read", {bus_we_o, bus_addr_o}, {1'b0, pc});
        end
        3: chk("R1 push hi", {bus_req_o, bus_we_o, bus_addr_o},
               {2'b11, 4'h0, spm2});
        4: chk("R1 push lo", {bus_req_o, bus_we_o, bus_addr_o},
               {2'b11, 4'h0, spm4});
        5: begin
          bus_rdata_i = w5;
          chk("R1 vector lo read", {bus_req_o, bus_we_o, bus_addr_o}, {2'b10, vec});
        end
        6: begin
          bus_rdata_i = w6;
          chk("R1 vector hi read", {bus_req_o, bus_we_o, bus_addr_o},
              {2'b10, vec + 20'd2});
        end
        default: chk("R9 idle slot", 32'(bus_req_o), 32'd0);
      endcase
      if (k == 3) chk("R1 push hi data", 32'(bus_wdata_o), 32'({pc[19:16], flg}));
      if (k == 4) chk("R1 push lo data", 32'(bus_wdata_o), 32'(pc[15:0]));
      if (k == t) chk("R7 new pc", 32'(new_pc_o), 32'({w6[3:0], w5}));
    end
    @(negedge clk);
    accept_i = 1'b0;
    exp_ipl = next_ipl(src, lvl, exp_ipl);
    chk("R8/R9 idle after done", 32'(busy_o), 32'd0);
    chk(src == 3'd0 ? "R5 ipl level" : "R6 ipl by source", 32'(ipl_o), 32'(exp_ipl));
    chk("R10 info word", 32'(info_o), 32'(w1));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9 reset busy", 32'(busy_o), 32'd0);
    chk("R2 reset done", 32'(done_o), 32'd0);
    chk("R1 reset bus", 32'(bus_req_o), 32'd0);
    chk("R6 reset ipl", 32'(ipl_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 parity corners, leveled source
    run_one(3'd0, 3'd5, 20'h01000, 16'h0800, 1'b0, 12'habc, 20'h54321, 1'b1, 0);
    run_one(3'd0, 3'd3, 20'h01001, 16'h0800, 1'b0, 12'h123, 20'h12345, 1'b0, 0);
    run_one(3'd0, 3'd2, 20'h01000, 16'h0801, 1'b0, 12'h456, 20'hfedcb, 1'b1, 0);
    run_one(3'd7, 3'd6, 20'hfffff, 16'h0001, 1'b0, 12'h789, 20'h0abcd, 1'b0, 0);
    // R3 bus8 parities
    run_one(3'd0, 3'd4, 20'h02000, 16'h0400, 1'b1, 12'h111, 20'h11111, 1'b1, 0);
    run_one(3'd7, 3'd1, 20'h02001, 16'h0401, 1'b1, 12'h222, 20'h22222, 1'b0, 0);
    // R4 class adders, R6 ipl rules
    run_one(3'd4, 3'd0, 20'h03000, 16'h0002, 1'b0, 12'h333, 20'h33333, 1'b1, 0);
    run_one(3'd5, 3'd0, 20'h03001, 16'h0003, 1'b1, 12'h444, 20'h44444, 1'b1, 0);
    run_one(3'd6, 3'd0, 20'h03002, 16'h0005, 1'b0, 12'h555, 20'h55555, 1'b0, 0);
    run_one(3'd1, 3'd0, 20'h04000, 16'h1000, 1'b0, 12'h666, 20'h66666, 1'b1, 0);
    run_one(3'd3, 3'd0, 20'h04000, 16'h1000, 1'b0, 12'h777, 20'h77777, 1'b1, 0);
    run_one(3'd2, 3'd0, 20'h04001, 16'h1001, 1'b1, 12'h888, 20'h88888, 1'b0, 0);
    // R8 stray accepts
    run_one(3'd0, 3'd1, 20'h05000, 16'h2000, 1'b0, 12'h999, 20'h99999, 1'b1, 1);
    run_one(3'd6, 3'd0, 20'h05001, 16'h2001, 1'b1, 12'haaa, 20'haaaaa, 1'b0, 2);
    for (int n = 0; n < 40; n++) begin
      run_one(3'($urandom), 3'($urandom), 20'($urandom), 16'($urandom), 1'($urandom),
              12'($urandom), 20'($urandom), 1'($urandom), int'($urandom % 3));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule